// File: doc/BRIEF.md
# Error Pin Toggle Monitor

This block supervises a heartbeat line from a processor's safety unit. While the processor is healthy, that unit drives a square wave onto the line, and the wave must toggle at a frequency inside a configured band. The monitor passes the raw line through a synchroniser and measures the time between consecutive rising edges in system clock cycles. It classifies each period as valid, too short or missing. A period that is too short is a fast fault. A line that is too slow or stuck is a slow fault, which a timeout detects.

A confirmed fault sets a sticky status flag and pulses an interrupt when that flag rises. It also pulses a fault-state request to the power-state controller around the block. Software selects one of two reaction modes. In the first, the block reports a fault as soon as it detects one. In the second, a detected fault starts a recovery window, and a valid period seen inside that window withdraws it.

Monitoring is active straight out of reset, using limits set by parameters. One configuration write loads the enable bit, the mode, both band limits and the recovery delay together. Each such write restarts the measurement.

Top module: `errpin_toggle_monitor`

## Requirements
- R1: After reset the monitor is enabled, in immediate mode, with limits DEF_MIN, DEF_MAX and DEF_RDLY. A line held low from reset raises the slow flag (flags bit 1) without any configuration write.
- R2: A rising-edge-to-rising-edge period P with min <= P <= max, counted in clock cycles, is valid and raises no fault.
- R3: A period P < min, measured between two rising edges with no timeout between them, is a fast fault and sets flags bit 0.
- R4: The slow fault (flags bit 1) fires when max+1 cycles pass without a rising edge, and again every max+1 cycles while the line stays quiet. The first rising edge after a timeout, an enable or a configuration write only starts a new measurement.
- R5: In immediate mode (cfg_delayed = 0), a detected fault sets its flag and pulses fault_req high for one cycle on the following clock edge. fault_req is never high while both flags are clear.
- R6: In delayed mode (cfg_delayed = 1), a fault opens a pending window. If no valid period arrives, the fault is reported cfg_rdly+1 cycles after detection, together with every fault kind seen during the window. A valid period inside the window cancels the report.
- R7: Flags are sticky. Writing 1 to flag_clr bit i clears flags bit i. A new fault on the same cycle wins over the clear.
- R8: irq pulses for one cycle only when at least one flag goes from 0 to 1. A fault whose flag is already set gives no irq.
- R9: With cfg_en = 0 the block holds its measurement in reset and produces no fault, no fault_req and no irq. flag_clr still works.
- R10: A configuration write discards any partial period and any pending fault, so an edge that arrives shortly after the write is not judged against the edge before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| err_pin | input | 1 | Raw heartbeat line, asynchronous to clk |
| cfg_wr | input | 1 | Loads all cfg_* fields for one cycle |
| cfg_en | input | 1 | Monitoring enable |
| cfg_delayed | input | 1 | 0 = report at once, 1 = report after recovery delay |
| cfg_min | input | CNT_W | Shortest valid period in cycles |
| cfg_max | input | CNT_W | Longest valid period in cycles |
| cfg_rdly | input | DLY_W | Recovery delay in cycles |
| flag_clr | input | 2 | Write-one-to-clear for flags (bit 0 fast, bit 1 slow) |
| flags | output | 2 | Sticky fault flags (bit 0 fast, bit 1 slow) |
| irq | output | 1 | One-cycle pulse when a flag becomes set |
| fault_req | output | 1 | One-cycle fault-state request per confirmed fault |

## Verification
A period counter that drifts by even one cycle becomes visible as a fault flag on the first edge near a band limit, or as a slow timeout one cycle early or late. A stale armed bit shows up as a fast fault on the first edge after a restart. A wrong pending state shows up as a fault_req that fires during a recovery window that should have been cancelled, or as a missing one at cfg_rdly+1 cycles. The reference model is compared with flags, irq and fault_req on every clock, so any such error is reported in the same cycle it reaches the ports.

// File: rtl/errmon_pkg.sv
package errmon_pkg;

    // Fault kinds; packed so that fast is bit 0 and slow is bit 1
    typedef struct packed {
        logic slow;
        logic fast;
    } fault_kind_t;

    typedef enum logic {
        MODE_IMMEDIATE = 1'b0,
        MODE_DELAYED   = 1'b1
    } react_mode_e;

    localparam int NUM_KINDS = 2;

    function automatic logic kind_any(input fault_kind_t k);
        return k.slow | k.fast;
    endfunction

    function automatic fault_kind_t kind_merge(input fault_kind_t a, input fault_kind_t b);
        fault_kind_t r;
        r.slow = a.slow | b.slow;
        r.fast = a.fast | b.fast;
        return r;
    endfunction

endpackage

// File: rtl/errmon_sync.sv
module errmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[CHAIN_W-2:0], pin};
    end

    // Edge taken after the last synchroniser flop
    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/errmon_period.sv
module errmon_period
    import errmon_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             rise,
    input  logic [CNT_W-1:0] min_p,
    input  logic [CNT_W-1:0] max_p,
    output fault_kind_t      evt,
    output logic             valid
);
    logic [CNT_W-1:0] cnt;
    logic             armed;
    logic             at_limit;
    logic             long_enough;

    always_comb begin
        at_limit    = (cnt == max_p);
        long_enough = ({1'b0, cnt} + 1'b1) >= {1'b0, min_p};
        evt.slow    = !restart && at_limit;
        evt.fast    = !restart && rise && armed && !at_limit && !long_enough;
        valid       = !restart && rise && armed && !at_limit && long_enough;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else begin
            cnt   <= (rise || at_limit) ? '0 : cnt + 1'b1;
            armed <= rise ? 1'b1 : (at_limit ? 1'b0 : armed);
        end
    end
endmodule

// File: rtl/errmon_react.sv
module errmon_react
    import errmon_pkg::*;
#(
    parameter int DLY_W = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 restart,
    input  react_mode_e          mode,
    input  logic [DLY_W-1:0]     rdly,
    input  fault_kind_t          evt,
    input  logic                 valid,
    input  logic [NUM_KINDS-1:0] clr,
    output logic [NUM_KINDS-1:0] flags,
    output logic                 irq,
    output logic                 fault_req
);
    logic             pend_q, pend_n;
    logic [DLY_W-1:0] dcnt_q, dcnt_n;
    fault_kind_t      pkind_q, pkind_n;
    fault_kind_t      conf;

    always_comb begin
        conf    = '0;
        pend_n  = pend_q;
        dcnt_n  = dcnt_q;
        pkind_n = pkind_q;
        if (restart) begin
            pend_n = 1'b0;
        end else if (mode == MODE_IMMEDIATE) begin
            conf   = evt;
            pend_n = 1'b0;
        end else if (pend_q) begin
            if (valid) begin
                pend_n = 1'b0;
            end else if (dcnt_q == rdly) begin
                conf   = kind_merge(pkind_q, evt);
                pend_n = 1'b0;
            end else begin
                dcnt_n  = dcnt_q + 1'b1;
                pkind_n = kind_merge(pkind_q, evt);
            end
        end else if (kind_any(evt)) begin
            pend_n  = 1'b1;
            dcnt_n  = '0;
            pkind_n = evt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= 1'b0;
            dcnt_q    <= '0;
            pkind_q   <= '0;
            flags     <= '0;
            irq       <= 1'b0;
            fault_req <= 1'b0;
        end else begin
            pend_q    <= pend_n;
            dcnt_q    <= dcnt_n;
            pkind_q   <= pkind_n;
            flags     <= (flags & ~clr) | conf;
            irq       <= |(conf & ~flags);
            fault_req <= kind_any(conf);
        end
    end
endmodule

// File: rtl/errpin_toggle_monitor.sv
module errpin_toggle_monitor
    import errmon_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DLY_W    = 12,
    parameter int SYNC_N   = 2,
    parameter int DEF_MIN  = 100,
    parameter int DEF_MAX  = 1000,
    parameter int DEF_RDLY = 500
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             err_pin,
    input  logic             cfg_wr,
    input  logic             cfg_en,
    input  logic             cfg_delayed,
    input  logic [CNT_W-1:0] cfg_min,
    input  logic [CNT_W-1:0] cfg_max,
    input  logic [DLY_W-1:0] cfg_rdly,
    input  logic [1:0]       flag_clr,
    output logic [1:0]       flags,
    output logic             irq,
    output logic             fault_req
);
    typedef struct packed {
        logic             en;
        react_mode_e      mode;
        logic [CNT_W-1:0] min_p;
        logic [CNT_W-1:0] max_p;
        logic [DLY_W-1:0] rdly;
    } mon_cfg_t;

    mon_cfg_t    cfg_q;
    logic        cfg_en_q;
    logic        rise;
    logic        restart;
    logic        valid;
    fault_kind_t evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.en    <= 1'b1;
            cfg_q.mode  <= MODE_IMMEDIATE;
            cfg_q.min_p <= CNT_W'(DEF_MIN);
            cfg_q.max_p <= CNT_W'(DEF_MAX);
            cfg_q.rdly  <= DLY_W'(DEF_RDLY);
        end else if (cfg_wr) begin
            cfg_q.en    <= cfg_en;
            cfg_q.mode  <= react_mode_e'(cfg_delayed);
            cfg_q.min_p <= cfg_min;
            cfg_q.max_p <= cfg_max;
            cfg_q.rdly  <= cfg_rdly;
        end
    end

    assign cfg_en_q = cfg_q.en;
    assign restart  = cfg_wr | ~cfg_q.en;

    errmon_sync #(.STAGES(SYNC_N)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pin  (err_pin),
        .rise (rise)
    );

    errmon_period #(.CNT_W(CNT_W)) u_period (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .rise    (rise),
        .min_p   (cfg_q.min_p),
        .max_p   (cfg_q.max_p),
        .evt     (evt),
        .valid   (valid)
    );

    errmon_react #(.DLY_W(DLY_W)) u_react (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .mode      (cfg_q.mode),
        .rdly      (cfg_q.rdly),
        .evt       (evt),
        .valid     (valid),
        .clr       (flag_clr),
        .flags     (flags),
        .irq       (irq),
        .fault_req (fault_req)
    );
endmodule

// File: rtl/errmon_checker.sv
module errmon_checker (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic [1:0] clr,
    input logic [1:0] flags,
    input logic       irq,
    input logic       fault_req
);
    p_fast_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (flags[0] && !clr[0]) |=> flags[0]);

    p_slow_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (flags[1] && !clr[1]) |=> flags[1]);

    p_irq_on_new_flag_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((flags & ~$past(flags)) != 2'b00));

    p_req_has_flag_r5: assert property (@(posedge clk) disable iff (rst)
        fault_req |-> (flags != 2'b00));

    p_disabled_silent_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!fault_req && !irq));
endmodule

bind errpin_toggle_monitor errmon_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (cfg_en_q),
    .clr       (flag_clr),
    .flags     (flags),
    .irq       (irq),
    .fault_req (fault_req)
);

// File: tb/errpin_toggle_monitor_tb.sv
module errpin_toggle_monitor_tb;
    localparam int CNT_W = 16;
    localparam int DLY_W = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             err_pin = 1'b0;
    logic             cfg_wr = 1'b0;
    logic             cfg_en = 1'b1;
    logic             cfg_delayed = 1'b0;
    logic [CNT_W-1:0] cfg_min = '0;
    logic [CNT_W-1:0] cfg_max = '0;
    logic [DLY_W-1:0] cfg_rdly = '0;
    logic [1:0]       flag_clr = '0;
    logic [1:0]       flags;
    logic             irq;
    logic             fault_req;

    int checks = 0;
    int failures = 0;
    int irq_cnt = 0;
    int req_cnt = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    errpin_toggle_monitor u_dut (
        .clk(clk), .rst(rst), .err_pin(err_pin),
        .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_delayed(cfg_delayed),
        .cfg_min(cfg_min), .cfg_max(cfg_max), .cfg_rdly(cfg_rdly),
        .flag_clr(flag_clr), .flags(flags), .irq(irq), .fault_req(fault_req)
    );

    // Behavioural reference model
    int m_d1, m_d2, m_d3, m_cnt, m_armed, m_pend, m_dcnt, m_pk;
    int m_flags, m_irq, m_req, m_en, m_min, m_max, m_del, m_rdly;
    int e_rise, e_slow, e_fast, e_valid, e_kind, e_conf;

    always @(posedge clk) begin
        if (rst) begin
            m_d1 = 0; m_d2 = 0; m_d3 = 0; m_cnt = 0; m_armed = 0;
            m_pend = 0; m_dcnt = 0; m_pk = 0; m_flags = 0; m_irq = 0; m_req = 0;
            m_en = 1; m_min = 100; m_max = 1000; m_del = 0; m_rdly = 500;
        end else begin
            e_rise = (m_d2 == 1 && m_d3 == 0) ? 1 : 0;
            e_conf = 0; e_slow = 0; e_fast = 0; e_valid = 0;
            if (cfg_wr || m_en == 0) begin
                m_cnt = 0; m_armed = 0; m_pend = 0;
            end else begin
                e_slow = (m_cnt == m_max) ? 1 : 0;
                if (e_rise == 1 && m_armed == 1 && e_slow == 0) begin
                    if (m_cnt + 1 < m_min) e_fast = 1;
                    else e_valid = 1;
                end
                e_kind = e_fast + 2 * e_slow;
                if (m_del == 0) begin
                    e_conf = e_kind; m_pend = 0;
                end else if (m_pend == 1) begin
                    if (e_valid == 1) m_pend = 0;
                    else if (m_dcnt == m_rdly) begin e_conf = m_pk | e_kind; m_pend = 0; end
                    else begin m_dcnt++; m_pk = m_pk | e_kind; end
                end else if (e_kind != 0) begin
                    m_pend = 1; m_dcnt = 0; m_pk = e_kind;
                end
                if (e_rise == 1 || e_slow == 1) m_cnt = 0; else m_cnt++;
                if (e_rise == 1) m_armed = 1; else if (e_slow == 1) m_armed = 0;
            end
            m_irq = ((e_conf & ~m_flags & 3) != 0) ? 1 : 0;
            m_flags = (m_flags & ~int'(flag_clr) & 3) | e_conf;
            m_req = (e_conf != 0) ? 1 : 0;
            if (cfg_wr) begin
                m_en = int'(cfg_en); m_del = int'(cfg_delayed);
                m_min = int'(cfg_min); m_max = int'(cfg_max); m_rdly = int'(cfg_rdly);
            end
            m_d3 = m_d2; m_d2 = m_d1; m_d1 = int'(err_pin);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Every-clock comparison, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(int'(flags) == m_flags, "R7 flags vs model", int'(flags), m_flags);
            chk(int'(irq) == m_irq, "R8 irq vs model", int'(irq), m_irq);
            chk(int'(fault_req) == m_req, "R5 fault_req vs model", int'(fault_req), m_req);
            if (irq) irq_cnt++;
            if (fault_req) req_cnt++;
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_cfg(input bit en, input bit del, input int mn, input int mx, input int rd);
        @(negedge clk);
        cfg_en = en; cfg_delayed = del;
        cfg_min = CNT_W'(mn); cfg_max = CNT_W'(mx); cfg_rdly = DLY_W'(rd);
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic clear_flags(input logic [1:0] v);
        @(negedge clk);
        flag_clr = v;
        @(negedge clk);
        flag_clr = 2'b00;
    endtask

    task automatic toggle(input int half, input int n);
        for (int i = 0; i < n; i++) begin
            err_pin = 1'b1; wait_cyc(half);
            err_pin = 1'b0; wait_cyc(half);
        end
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        int snap_req, snap_irq;
        wait_cyc(3);
        rst = 1'b0;
        @(negedge clk);
        chk(flags == 2'b00, "R7 reset flags", int'(flags), 0);
        chk(irq == 1'b0, "R8 reset irq", int'(irq), 0);
        chk(fault_req == 1'b0, "R5 reset fault_req", int'(fault_req), 0);

        // R1: enabled by default; stuck low line times out at default limit
        wait_cyc(1100);
        chk(flags[1] == 1'b1, "R1 default slow fault", int'(flags[1]), 1);
        clear_flags(2'b11);
        @(negedge clk);
        chk(flags == 2'b00, "R7 write-one clear", int'(flags), 0);

        // R2: valid band, immediate mode
        write_cfg(1, 0, 6, 20, 10);
        toggle(5, 8);
        chk(flags == 2'b00, "R2 valid period no fault", int'(flags), 0);

        // R3, R5, R8: burst of short periods
        snap_irq = irq_cnt; snap_req = req_cnt;
        toggle(2, 6);
        toggle(5, 4);
        chk(flags == 2'b01, "R3 fast flag only", int'(flags), 1);
        chk(irq_cnt - snap_irq == 1, "R8 single irq for repeated fault", irq_cnt - snap_irq, 1);
        chk(req_cnt - snap_req > 1, "R5 request per fault", req_cnt - snap_req, 2);

        // R4: stuck line
        err_pin = 1'b0;
        wait_cyc(50);
        chk(flags[1] == 1'b1, "R4 slow timeout", int'(flags[1]), 1);
        clear_flags(2'b11);

        // R6: delayed mode, short glitch cancelled by valid period
        write_cfg(1, 1, 6, 20, 30);
        toggle(5, 4);
        snap_req = req_cnt;
        toggle(2, 1);
        toggle(5, 4);
        wait_cyc(2);
        chk(flags == 2'b00, "R6 pending fault cancelled", int'(flags), 0);
        chk(req_cnt == snap_req, "R6 no request when cancelled", req_cnt - snap_req, 0);

        // R6: stuck line in delayed mode is confirmed later
        err_pin = 1'b0;
        wait_cyc(30);
        chk(flags == 2'b00, "R6 not yet reported", int'(flags), 0);
        wait_cyc(60);
        chk(flags[1] == 1'b1, "R6 confirmed after delay", int'(flags[1]), 1);
        clear_flags(2'b11);

        // R9: disabled block stays silent
        write_cfg(0, 0, 6, 20, 10);
        snap_req = req_cnt;
        toggle(1, 20);
        wait_cyc(100);
        chk(req_cnt == snap_req, "R9 no request while disabled", req_cnt - snap_req, 0);
        chk(flags == 2'b00, "R9 no flag while disabled", int'(flags), 0);

        // R10: configuration write restarts the measurement
        write_cfg(1, 0, 12, 40, 10);
        err_pin = 1'b1;
        wait_cyc(6);
        write_cfg(1, 0, 12, 40, 10);
        err_pin = 1'b0; wait_cyc(2);
        err_pin = 1'b1; wait_cyc(8);
        err_pin = 1'b0; wait_cyc(8);
        toggle(8, 3);
        chk(flags == 2'b00, "R10 restart discards old edge", int'(flags), 0);

        finished = 1;
        summary();
        $finish;
    end
endmodule